// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C controller and decides whether the node is being addressed after a START condition. The receiver hands over each address byte with a one-cycle valid strobe. The matcher compares it against the node's own address, either 7-bit or 10-bit as chosen by a mode input. It can also recognise the all-zero general call byte when that feature is enabled.

A successful match, or a recognised general call, produces a one-cycle pulse. The matcher then latches the received read/write bit as the transfer direction and asks the controller to leave master mode. A lost arbitration, reported on an input, raises the same request. The direction bit can also be written from the register side, but only while the controller is in master mode. In slave mode the hardware alone sets it.

Top module: `slv_addr_match`

## Requirements
- R1: While `enable_i` is 0, and after reset, `match_o`, `gcall_o` and `drop_master_o` are 0, `dir_o` is 0, and the matcher ignores every byte until it sees a new START while enabled.
- R2: With `ext_addr_i` = 0, the first byte after START whose bits [7:1] equal `own_addr_i[6:0]` gives a `match_o` pulse in the cycle after its strobe. A byte of 0x00 never counts as an own-address match.
- R3: With `ext_addr_i` = 1, the first byte must be 11110 in bits [7:3], `own_addr_i[9:8]` in bits [2:1], and the R/W bit in bit 0. The second byte must equal `own_addr_i[7:0]`. `match_o` pulses in the cycle after the second strobe only, and never after the first.
- R4: A first byte of 0x00 with `gcall_en_i` = 1 gives a `gcall_o` pulse in the following cycle. With `gcall_en_i` = 0 the byte has no effect on any output.
- R5: On a match, `dir_o` takes the received R/W bit (bit 0 of the first address byte) in the same cycle as `match_o`. A general call sets `dir_o` to 0.
- R6: A register write (`dir_we_i` = 1) loads `dir_wdata_i` into `dir_o` one cycle later only when `master_i` = 1. With `master_i` = 0 the write is ignored. A hardware capture in the same cycle wins over a write.
- R7: `drop_master_o` is 1 in the cycle after an own-address match, after a general call, or after any enabled cycle in which `arb_lost_i` is 1.
- R8: `stop_i` returns the matcher to idle, so that later bytes are ignored. `start_i` restarts address decoding and discards a half-received 10-bit address. START or STOP wins over a byte strobe in the same cycle.
- R9: Only the address byte(s) right after START are examined. A byte that follows a completed or failed address phase never produces a pulse.
- R10: `match_o` and `gcall_o` are never 1 in two consecutive cycles.
- R11: With `ext_addr_i` = 1, a byte that would match in 7-bit mode does not match unless it also satisfies the 10-bit header rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Module enable; 0 holds the matcher in reset |
| ext_addr_i | input | 1 | 1 selects the 10-bit own address, 0 the 7-bit own address |
| gcall_en_i | input | 1 | Enables recognition of the general call byte |
| own_addr_i | input | 10 | Own slave address (bits [6:0] used in 7-bit mode) |
| start_i | input | 1 | START or repeated START seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte, MSB first on the wire, R/W in bit 0 |
| arb_lost_i | input | 1 | Arbitration lost indication |
| master_i | input | 1 | Controller currently in master mode |
| dir_we_i | input | 1 | Register-side write strobe for the direction bit |
| dir_wdata_i | input | 1 | Value for the direction write |
| match_o | output | 1 | One-cycle pulse: own address matched |
| gcall_o | output | 1 | One-cycle pulse: general call recognised |
| dir_o | output | 1 | Transfer direction (1 = master reads) |
| drop_master_o | output | 1 | One-cycle request to clear master mode |

## Verification
Every result is registered once. For a strobe, START, STOP, arbitration flag or direction write presented in one cycle, `match_o`, `gcall_o`, `drop_master_o` and `dir_o` change on the next rising edge. The bench drives each stimulus just after a falling edge and compares all four outputs at the following falling edge. It compares them against a cycle model that advances one step per driven cycle. Reset is checked only after the internal synchroniser has released, and enable changes are checked on the cycle that follows them.

// File: rtl/slv_am_pkg.sv
package slv_am_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR10_W = 10;
  localparam int ADDR7_W  = BYTE_W - 1;
  localparam int HI_W     = ADDR10_W - BYTE_W;
  localparam int HDR_W    = BYTE_W - 1 - HI_W;
  localparam logic [HDR_W-1:0] HDR10 = 5'b11110;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_DONE   = 2'd3
  } am_phase_e;
endpackage

// File: rtl/slv_am_rst_sync.sv
module slv_am_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/slv_am_cmp.sv
module slv_am_cmp
  import slv_am_pkg::*;
(
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic [ADDR10_W-1:0] own_i,
  output logic                zero_o,
  output logic                hit7_o,
  output logic                hdr10_o,
  output logic                lo10_o,
  output logic                rw_o
);
  assign zero_o  = (byte_i == '0);
  assign hit7_o  = (byte_i[BYTE_W-1:1] == own_i[ADDR7_W-1:0]);
  assign hdr10_o = (byte_i[BYTE_W-1:BYTE_W-HDR_W] == HDR10) &&
                   (byte_i[HI_W:1] == own_i[ADDR10_W-1:BYTE_W]);
  assign lo10_o  = (byte_i == own_i[BYTE_W-1:0]);
  assign rw_o    = byte_i[0];
endmodule

// File: rtl/slv_am_fsm.sv
module slv_am_fsm
  import slv_am_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ext_i,
  input  logic gc_en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic vld_i,
  input  logic zero_i,
  input  logic hit7_i,
  input  logic hdr10_i,
  input  logic lo10_i,
  input  logic rw_i,
  input  logic arb_lost_i,
  output logic match_o,
  output logic gcall_o,
  output logic drop_o,
  output logic cap_o,
  output logic cap_val_o
);
  am_phase_e ph_q, ph_d;
  logic rw_q, rw_d;
  logic hit_d, gc_d, drop_d;

  always_comb begin
    ph_d      = ph_q;
    rw_d      = rw_q;
    hit_d     = 1'b0;
    gc_d      = 1'b0;
    cap_o     = 1'b0;
    cap_val_o = 1'b0;
    if (!en_i) begin
      ph_d = PH_OFF;
    end else if (start_i) begin
      ph_d = PH_FIRST;
    end else if (stop_i) begin
      ph_d = PH_OFF;
    end else if (vld_i) begin
      unique case (ph_q)
        PH_FIRST: begin
          ph_d = PH_DONE;
          if (zero_i) begin
            if (gc_en_i) begin
              gc_d      = 1'b1;
              cap_o     = 1'b1;
              cap_val_o = 1'b0;
            end
          end else if (!ext_i) begin
            if (hit7_i) begin
              hit_d     = 1'b1;
              cap_o     = 1'b1;
              cap_val_o = rw_i;
            end
          end else if (hdr10_i) begin
            ph_d = PH_SECOND;
            rw_d = rw_i;
          end
        end
        PH_SECOND: begin
          ph_d = PH_DONE;
          if (lo10_i) begin
            hit_d     = 1'b1;
            cap_o     = 1'b1;
            cap_val_o = rw_q;
          end
        end
        default: ;
      endcase
    end
    drop_d = en_i & (hit_d | gc_d | arb_lost_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_OFF;
      rw_q    <= 1'b0;
      match_o <= 1'b0;
      gcall_o <= 1'b0;
      drop_o  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      rw_q    <= rw_d;
      match_o <= hit_d;
      gcall_o <= gc_d;
      drop_o  <= drop_d;
    end
  end

  a_r1_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!match_o && !gcall_o && !drop_o && ph_q == PH_OFF));
  a_r3_no_match_on_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SECOND) |-> !match_o);
  a_r4_gc_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_o |-> ($past(gc_en_i) && $past(zero_i)));
  a_r7_arb_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && arb_lost_i) |=> drop_o);
  a_r7_hit_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || gcall_o) |-> drop_o);
  a_r8_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && stop_i) |=> (ph_q == PH_OFF));
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DONE && !start_i) |=> (!match_o && !gcall_o));
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || gcall_o) |=> (!match_o && !gcall_o));
endmodule

// File: rtl/slv_am_dir.sv
module slv_am_dir (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic master_i,
  input  logic we_i,
  input  logic wdata_i,
  input  logic cap_i,
  input  logic cap_val_i,
  output logic dir_o
);
  logic dir_d, dir_ce;

  always_comb begin
    dir_ce = 1'b0;
    dir_d  = dir_o;
    if (!en_i) begin
      dir_ce = 1'b1;
      dir_d  = 1'b0;
    end else if (cap_i) begin
      dir_ce = 1'b1;
      dir_d  = cap_val_i;
    end else if (we_i && master_i) begin
      dir_ce = 1'b1;
      dir_d  = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_o <= 1'b0;
    else if (dir_ce) dir_o <= dir_d;
  end

  a_r6_slave_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !master_i && we_i && !cap_i) |=> (dir_o == $past(dir_o)));
  a_r6_master_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && we_i && !cap_i) |=> (dir_o == $past(wdata_i)));
  a_r5_capture_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cap_i) |=> (dir_o == $past(cap_val_i)));
endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
  import slv_am_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                ext_addr_i,
  input  logic                gcall_en_i,
  input  logic [ADDR10_W-1:0] own_addr_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                byte_vld_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                arb_lost_i,
  input  logic                master_i,
  input  logic                dir_we_i,
  input  logic                dir_wdata_i,
  output logic                match_o,
  output logic                gcall_o,
  output logic                dir_o,
  output logic                drop_master_o
);
  logic rst_n;
  logic zero, hit7, hdr10, lo10, rw;
  logic cap, cap_val;

  slv_am_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  slv_am_cmp u_cmp (
    .byte_i  (byte_i),
    .own_i   (own_addr_i),
    .zero_o  (zero),
    .hit7_o  (hit7),
    .hdr10_o (hdr10),
    .lo10_o  (lo10),
    .rw_o    (rw)
  );

  slv_am_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (enable_i),
    .ext_i      (ext_addr_i),
    .gc_en_i    (gcall_en_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .vld_i      (byte_vld_i),
    .zero_i     (zero),
    .hit7_i     (hit7),
    .hdr10_i    (hdr10),
    .lo10_i     (lo10),
    .rw_i       (rw),
    .arb_lost_i (arb_lost_i),
    .match_o    (match_o),
    .gcall_o    (gcall_o),
    .drop_o     (drop_master_o),
    .cap_o      (cap),
    .cap_val_o  (cap_val)
  );

  slv_am_dir u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (enable_i),
    .master_i  (master_i),
    .we_i      (dir_we_i),
    .wdata_i   (dir_wdata_i),
    .cap_i     (cap),
    .cap_val_i (cap_val),
    .dir_o     (dir_o)
  );

  a_r2_match_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    match_o |-> $past(byte_vld_i && enable_i && !start_i && !stop_i));
endmodule

// File: tb/tb_slv_addr_match.sv
module tb_slv_addr_match;
  logic clk = 1'b0;
  logic rst_ni;
  logic enable_i, ext_addr_i, gcall_en_i;
  logic [9:0] own_addr_i;
  logic start_i, stop_i, byte_vld_i;
  logic [7:0] byte_i;
  logic arb_lost_i, master_i, dir_we_i, dir_wdata_i;
  logic match_o, gcall_o, dir_o, drop_master_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int m_ph;
  bit m_rw, m_dir;

  always #5 clk = ~clk;

  slv_addr_match dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .ext_addr_i(ext_addr_i),
    .gcall_en_i(gcall_en_i), .own_addr_i(own_addr_i), .start_i(start_i),
    .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .arb_lost_i(arb_lost_i), .master_i(master_i), .dir_we_i(dir_we_i),
    .dir_wdata_i(dir_wdata_i), .match_o(match_o), .gcall_o(gcall_o),
    .dir_o(dir_o), .drop_master_o(drop_master_o)
  );

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // One driven cycle: model computes expectation, outputs compared one edge later.
  task automatic step(input string rq, input bit st, input bit sp, input bit v,
                      input logic [7:0] b, input bit arb, input bit we, input bit wd);
    bit em, eg, ed;
    em = 0; eg = 0;
    start_i = st; stop_i = sp; byte_vld_i = v; byte_i = b;
    arb_lost_i = arb; dir_we_i = we; dir_wdata_i = wd;
    if (!enable_i) begin
      m_ph = 0; m_dir = 0;
    end else begin
      if (st) m_ph = 1;
      else if (sp) m_ph = 0;
      else if (v) begin
        if (m_ph == 1) begin
          m_ph = 3;
          if (b == 8'h00) begin
            if (gcall_en_i) begin eg = 1; m_dir = 0; end
          end else if (!ext_addr_i) begin
            if (b[7:1] == own_addr_i[6:0]) begin em = 1; m_dir = b[0]; end
          end else if (b[7:3] == 5'b11110 && b[2:1] == own_addr_i[9:8]) begin
            m_ph = 2; m_rw = b[0];
          end
        end else if (m_ph == 2) begin
          m_ph = 3;
          if (b == own_addr_i[7:0]) begin em = 1; m_dir = m_rw; end
        end
      end
      if (!(em || eg) && we && master_i) m_dir = wd;
    end
    ed = enable_i && (em || eg || arb);
    @(negedge clk);
    chk(rq, "match_o", match_o, em);
    chk(rq, "gcall_o", gcall_o, eg);
    chk(rq, "drop_master_o R7", drop_master_o, ed);
    chk(rq, "dir_o R5/R6", dir_o, m_dir);
    start_i = 0; stop_i = 0; byte_vld_i = 0; arb_lost_i = 0; dir_we_i = 0;
  endtask

  task automatic idle(input string rq);
    step(rq, 0, 0, 0, 8'h00, 0, 0, 0);
  endtask

  function automatic logic [7:0] pick_byte();
    int k;
    k = $urandom_range(0, 6);
    case (k)
      0: return {own_addr_i[6:0], 1'($urandom_range(0, 1))};
      1: return {5'b11110, own_addr_i[9:8], 1'($urandom_range(0, 1))};
      2: return own_addr_i[7:0];
      3: return 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_ni = 0; enable_i = 0; ext_addr_i = 0; gcall_en_i = 0; own_addr_i = 10'h02A;
    start_i = 0; stop_i = 0; byte_vld_i = 0; byte_i = 0; arb_lost_i = 0;
    master_i = 0; dir_we_i = 0; dir_wdata_i = 0;
    m_ph = 0; m_rw = 0; m_dir = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "match_o after reset", match_o, 1'b0);
    chk("R1", "gcall_o after reset", gcall_o, 1'b0);
    chk("R1", "dir_o after reset", dir_o, 1'b0);
    chk("R1", "drop_master_o after reset", drop_master_o, 1'b0);

    // R1 disabled: a matching sequence does nothing
    step("R1", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R1", 0, 0, 1, 8'h55, 1, 0, 0);
    enable_i = 1;
    idle("R1");
    // enabled but no START yet: byte ignored
    step("R1", 0, 0, 1, 8'h55, 0, 0, 0);

    // R2 / R5 7-bit match, read direction
    step("R2", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R2", 0, 0, 1, 8'h55, 0, 0, 0);
    idle("R10");
    // R9 later data byte of same value
    step("R9", 0, 0, 1, 8'h55, 0, 0, 0);
    // R6 slave write ignored, master write lands
    master_i = 0; step("R6", 0, 0, 0, 8'h00, 0, 1, 0);
    master_i = 1; step("R6", 0, 0, 0, 8'h00, 0, 1, 0);
    step("R6", 0, 0, 0, 8'h00, 0, 1, 1);
    master_i = 0;
    // R2 zero byte with own 0 is not a match
    own_addr_i = 10'h000;
    step("R2", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R2", 0, 0, 1, 8'h00, 0, 0, 0);
    // R4 general call
    gcall_en_i = 1;
    step("R4", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R4", 0, 0, 1, 8'h00, 0, 0, 0);
    idle("R10");
    gcall_en_i = 0;

    // R3 10-bit
    own_addr_i = 10'h3A5; ext_addr_i = 1;
    step("R3", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R3", 0, 0, 1, 8'hF7, 0, 0, 0);
    step("R3", 0, 0, 1, 8'hA5, 0, 0, 0);
    // R11 7-bit form in 10-bit mode
    own_addr_i = 10'h3D2;
    step("R11", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R11", 0, 0, 1, 8'hA4, 0, 0, 0);
    step("R11", 0, 0, 1, 8'hD2, 0, 0, 0);
    // R8 START in the middle of a 10-bit address
    own_addr_i = 10'h3A5;
    step("R8", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R8", 0, 0, 1, 8'hF6, 0, 0, 0);
    step("R8", 1, 0, 1, 8'hA5, 0, 0, 0);
    step("R8", 0, 0, 1, 8'hA5, 0, 0, 0);
    // R8 STOP then bytes ignored
    ext_addr_i = 0; own_addr_i = 10'h02A;
    step("R8", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R8", 0, 1, 0, 8'h00, 0, 0, 0);
    step("R8", 0, 0, 1, 8'h54, 0, 0, 0);
    // R7 arbitration loss
    step("R7", 0, 0, 0, 8'h00, 1, 0, 0);
    idle("R7");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) enable_i = ~enable_i;
      if ($urandom_range(0, 99) < 2) ext_addr_i = ~ext_addr_i;
      if ($urandom_range(0, 99) < 2) gcall_en_i = ~gcall_en_i;
      if ($urandom_range(0, 99) < 2) own_addr_i = 10'($urandom);
      if ($urandom_range(0, 99) < 5) master_i = ~master_i;
      step("rand", $urandom_range(0, 9) == 0, $urandom_range(0, 19) == 0,
           $urandom_range(0, 2) != 0, pick_byte(), $urandom_range(0, 19) == 0,
           $urandom_range(0, 9) == 0, 1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule